// File: doc/BRIEF.md
# Physical Memory Protection Checker with Machine Lockdown

This block decides whether one physical access may proceed. It holds a table of sixteen protection entries, each made of an 8-bit configuration field and an address register. Every cycle it may receive one access, made up of a byte address, an access kind (read, write or execute) and a privilege level (machine, supervisor or user). One clock edge later it reports either allow or fault. The table is scanned in index order, and the lowest-numbered entry whose region covers the access word decides the outcome.

A small security register sits beside the table. It controls three things. The first is a bypass that lets machine software rewrite locked entries. This bypass can only ever be turned off. The second is a policy that denies machine accesses hitting no entry. The third is a lockdown mode, which cannot be undone and which gives every entry's lock/read/write/execute bits a new meaning per privilege, so that regions can be machine-only, user-only or shared. Software programs everything through a single CSR write port. Every write to the table or to the security register produces a one-cycle flush strobe, telling the translation cache to drop what it holds.

Top module: `pmp_guard`

## Requirements
- R1: After reset `res_valid`, `res_allow`, `res_fault` and `flush_o` are 0. All entries are OFF. The security register starts with bypass=1, whitelist=0 and lockdown=0.
- R2: Entry configuration byte: bit0 R, bit1 W, bit2 X, bits 4:3 match mode (0 OFF, 1 TOR, 2 NA4, 3 NAPOT), bit7 L. The address register holds byte address bits [ADDR_W-1:2]. Match rules: NA4 covers one word. TOR covers [previous entry's address, own address), with 0 as the lower bound for entry 0. NAPOT covers a naturally aligned block of 2^(t+1) words, where t is the number of trailing ones in the address register.
- R3: When several entries match, the lowest-numbered matching entry alone decides the result.
- R4: With lockdown off, a machine access matching an entry with L=0 is allowed. A machine access matching an entry with L=1 needs that entry's R/W/X bit. A supervisor or user access needs the R/W/X bit of the matching entry. Access kind codes are 0 read, 1 write, 2 execute; code 3 is always denied. Privilege codes are 3 machine, 1 supervisor, 0 user, and 2 is treated as a lower privilege.
- R5: Supervisor and user accesses that match no entry are denied. A machine access matching no entry is denied while whitelist=1 and, with lockdown off, allowed while whitelist=0.
- R6: With lockdown on, the matching entry's {L,R,W,X} decides as follows. 0010: machine read/write, others read. 0011: read/write for all. 1010: execute for all. 1011: machine read/execute, others execute. 1111: read for all. Any other code with L=1 gives machine-only rights R/W/X, and with L=0 gives lower-privilege-only rights R/W/X.
- R7: With lockdown on, a machine access matching no entry is denied for execute. For read or write it is allowed unless whitelist=1.
- R8: Once the lockdown bit is 1, writes cannot clear it.
- R9: Once the bypass bit is 0, writes cannot set it. The whitelist bit takes each written value.
- R10: While bypass=0, writes to the configuration byte or address register of an entry with L=1 are ignored. A write to address register i is also ignored when entry i+1 has L=1 and mode TOR.
- R11: While bypass=1, entries with L=1 accept writes.
- R12: A write of kind 0 (configuration word; index k selects entries 4k..4k+3, byte j in bits 8j+7:8j), kind 1 (address register, index selects entry) or kind 2 (security register: bit2 bypass, bit1 whitelist, bit0 lockdown) sets `flush_o` for exactly the next cycle. Kind 3 writes nothing and does not flush.
- R13: A result appears one cycle after `acc_valid`. In that cycle exactly one of `res_allow` and `res_fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | CSR write strobe |
| csr_kind | input | 2 | Write target: 0 configuration word, 1 address register, 2 security register, 3 none |
| csr_idx | input | 4 | Configuration word index or entry index |
| csr_wdata | input | 32 | Write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 34 | Byte address of the access |
| acc_type | input | 2 | 0 read, 1 write, 2 execute |
| acc_priv | input | 2 | 3 machine, 1 supervisor, 0 user |
| res_valid | output | 1 | Result valid, one cycle after the access |
| res_allow | output | 1 | Access permitted |
| res_fault | output | 1 | Access denied |
| flush_o | output | 1 | One-cycle translation-cache flush strobe |

## Verification
The bench targets the following corner cases:
- Priority. An address sits inside both a NAPOT block and a TOR range. A checker that let the later entry win would allow an execute that should fault.
- Bypass ratchet. The bench clears the bypass and then tries to set it again. A design that re-armed the bypass would accept a rewrite of a locked entry, and the bench would see that entry's permissions change.
- TOR neighbour lock. The bench writes the lower bound of a locked TOR region. A design that accepted the write would shrink the region and let a machine write through.
- Lockdown decode. The bench probes each shared encoding from both privilege sides, checks the execute denial for unmatched machine fetches, and checks that lockdown survives a clearing write. A design that left lockdown clearable would return to allowing machine reads in a user-only region.

// File: rtl/pmp_guard_pkg.sv
package pmp_guard_pkg;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  // stored entry configuration (reserved bits dropped)
  typedef struct packed {
    logic   lock;
    amode_e mode;
    logic   x;
    logic   w;
    logic   r;
  } ecfg_t;

  typedef struct packed {
    logic rlb;
    logic mmwp;
    logic mml;
  } sec_t;

  localparam logic [1:0] PRIV_M = 2'd3;
  localparam logic [1:0] ACC_R  = 2'd0;
  localparam logic [1:0] ACC_W  = 2'd1;
  localparam logic [1:0] ACC_X  = 2'd2;

  localparam logic [1:0] K_CFG  = 2'd0;
  localparam logic [1:0] K_ADDR = 2'd1;
  localparam logic [1:0] K_SEC  = 2'd2;

  function automatic logic pick_right(input logic r, input logic w, input logic x,
                                      input logic [1:0] kind);
    case (kind)
      ACC_R:   return r;
      ACC_W:   return w;
      ACC_X:   return x;
      default: return 1'b0;
    endcase
  endfunction

  // lockdown-mode rights; lrwx = {L,R,W,X}
  function automatic logic lockdown_right(input logic [3:0] lrwx, input logic is_m,
                                          input logic [1:0] kind);
    logic mr, mw, mx, sr, sw, sx;
    {mr, mw, mx, sr, sw, sx} = 6'b0;
    case (lrwx)
      4'b0010: begin mr = 1'b1; mw = 1'b1; sr = 1'b1; end
      4'b0011: begin mr = 1'b1; mw = 1'b1; sr = 1'b1; sw = 1'b1; end
      4'b1010: begin mx = 1'b1; sx = 1'b1; end
      4'b1011: begin mr = 1'b1; mx = 1'b1; sx = 1'b1; end
      4'b1111: begin mr = 1'b1; sr = 1'b1; end
      default: begin
        if (lrwx[3]) {mr, mw, mx} = lrwx[2:0];
        else         {sr, sw, sx} = lrwx[2:0];
      end
    endcase
    return is_m ? pick_right(mr, mw, mx, kind) : pick_right(sr, sw, sx, kind);
  endfunction

endpackage

// File: rtl/pmp_regs.sv
module pmp_regs import pmp_guard_pkg::*; #(
  parameter int N      = 16,
  parameter int WA     = 32,
  parameter int DATA_W = 32,
  localparam int IW    = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 csr_we,
  input  logic [1:0]           csr_kind,
  input  logic [IW-1:0]        csr_idx,
  input  logic [DATA_W-1:0]    csr_wdata,
  output ecfg_t [N-1:0]        cfg_o,
  output logic [N-1:0][WA-1:0] addr_o,
  output logic                 mml_o,
  output logic                 mmwp_o,
  output logic                 flush_o
);

  localparam int BPW = DATA_W / 8;   // entries per configuration word

  ecfg_t [N-1:0]        cfg_q;
  logic [N-1:0][WA-1:0] addr_q;
  sec_t                 sec_q;
  logic                 flush_q;
  logic [N-1:0]         cfg_locked;
  logic [N-1:0]         addr_locked;

  for (genvar g = 0; g < N; g++) begin : g_lock
    assign cfg_locked[g] = cfg_q[g].lock & ~sec_q.rlb;
    if (g < N - 1) begin : g_nb
      assign addr_locked[g] = cfg_locked[g] |
                              (cfg_locked[g+1] & (cfg_q[g+1].mode == AM_TOR));
    end else begin : g_last
      assign addr_locked[g] = cfg_locked[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      addr_q  <= '0;
      sec_q   <= 3'b100;
      flush_q <= 1'b0;
    end else begin
      flush_q <= csr_we && (csr_kind != 2'd3);
      if (csr_we) begin
        case (csr_kind)
          K_CFG: begin
            for (int i = 0; i < N; i++) begin
              if ((i / BPW) == int'(csr_idx) && !cfg_locked[i]) begin
                cfg_q[i] <= ecfg_t'({csr_wdata[8*(i%BPW)+7], csr_wdata[8*(i%BPW) +: 5]});
              end
            end
          end
          K_ADDR: begin
            for (int i = 0; i < N; i++) begin
              if (i == int'(csr_idx) && !addr_locked[i]) addr_q[i] <= csr_wdata[WA-1:0];
            end
          end
          K_SEC: begin
            sec_q.mml  <= sec_q.mml | csr_wdata[0];
            sec_q.mmwp <= csr_wdata[1];
            sec_q.rlb  <= sec_q.rlb & csr_wdata[2];
          end
          default: ;
        endcase
      end
    end
  end

  assign cfg_o   = cfg_q;
  assign addr_o  = addr_q;
  assign mml_o   = sec_q.mml;
  assign mmwp_o  = sec_q.mmwp;
  assign flush_o = flush_q;

  a_r8_lockdown_sticky: assert property (@(posedge clk) disable iff (rst)
    sec_q.mml |=> sec_q.mml);

  a_r9_bypass_oneway: assert property (@(posedge clk) disable iff (rst)
    !sec_q.rlb |=> !sec_q.rlb);

  a_r12_flush_follows_write: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_kind != 2'd3) |=> flush_o);

  a_r12_flush_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !(csr_we && csr_kind != 2'd3) |=> !flush_o);

  for (genvar g = 0; g < N; g++) begin : g_chk
    a_r10_locked_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
      cfg_locked[g] |=> $stable(cfg_q[g]));
  end

endmodule

// File: rtl/pmp_entry_match.sv
module pmp_entry_match import pmp_guard_pkg::*; #(
  parameter int WA = 32
) (
  input  amode_e          mode,
  input  logic [WA-1:0]   lo_a,
  input  logic [WA-1:0]   hi_a,
  input  logic [WA-1:0]   acc_a,
  output logic            hit
);

  localparam logic [WA-1:0] ONE = WA'(1);

  logic [WA-1:0] keep_mask;

  always_comb begin
    keep_mask = ~(hi_a ^ (hi_a + ONE));
    case (mode)
      AM_TOR:   hit = (acc_a >= lo_a) && (acc_a < hi_a);
      AM_NA4:   hit = (acc_a == hi_a);
      AM_NAPOT: hit = ((acc_a & keep_mask) == (hi_a & keep_mask));
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmp_resolve.sv
module pmp_resolve import pmp_guard_pkg::*; #(
  parameter int N = 16
) (
  input  logic [N-1:0]      hit,
  input  logic [N-1:0][3:0] lrwx,
  input  logic              mml,
  input  logic              mmwp,
  input  logic [1:0]        acc_type,
  input  logic [1:0]        acc_priv,
  output logic              allow,
  output logic              any_hit
);

  logic [3:0] sel;
  logic       is_m;

  always_comb begin
    sel     = 4'b0;
    any_hit = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel     = lrwx[i];
        any_hit = 1'b1;
      end
    end
    is_m = (acc_priv == PRIV_M);
    if (acc_type == 2'd3) begin
      allow = 1'b0;
    end else if (!any_hit) begin
      allow = is_m && !mmwp && !(mml && acc_type == ACC_X);
    end else if (mml) begin
      allow = lockdown_right(sel, is_m, acc_type);
    end else if (is_m && !sel[3]) begin
      allow = 1'b1;
    end else begin
      allow = pick_right(sel[2], sel[1], sel[0], acc_type);
    end
  end

endmodule

// File: rtl/pmp_guard.sv
module pmp_guard import pmp_guard_pkg::*; #(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 34,
  parameter int DATA_W      = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           csr_we,
  input  logic [1:0]                     csr_kind,
  input  logic [$clog2(NUM_ENTRIES)-1:0] csr_idx,
  input  logic [DATA_W-1:0]              csr_wdata,
  input  logic                           acc_valid,
  input  logic [ADDR_W-1:0]              acc_addr,
  input  logic [1:0]                     acc_type,
  input  logic [1:0]                     acc_priv,
  output logic                           res_valid,
  output logic                           res_allow,
  output logic                           res_fault,
  output logic                           flush_o
);

  localparam int WA = ADDR_W - 2;

  ecfg_t [NUM_ENTRIES-1:0]        cfg_w;
  logic [NUM_ENTRIES-1:0][WA-1:0] addr_w;
  logic [NUM_ENTRIES-1:0][3:0]    perm_w;
  logic [NUM_ENTRIES-1:0]         hit_w;
  logic                           mml_w, mmwp_w;
  logic                           allow_w, any_hit_w;
  logic [WA-1:0]                  acc_word;
  logic                           unused_lo;

  assign acc_word  = acc_addr[ADDR_W-1:2];
  assign unused_lo = ^acc_addr[1:0];

  pmp_regs #(.N(NUM_ENTRIES), .WA(WA), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .csr_we   (csr_we),
    .csr_kind (csr_kind),
    .csr_idx  (csr_idx),
    .csr_wdata(csr_wdata),
    .cfg_o    (cfg_w),
    .addr_o   (addr_w),
    .mml_o    (mml_w),
    .mmwp_o   (mmwp_w),
    .flush_o  (flush_o)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic [WA-1:0] lo;
    if (g == 0) begin : g_first
      assign lo = '0;
    end else begin : g_rest
      assign lo = addr_w[g-1];
    end
    pmp_entry_match #(.WA(WA)) u_match (
      .mode (cfg_w[g].mode),
      .lo_a (lo),
      .hi_a (addr_w[g]),
      .acc_a(acc_word),
      .hit  (hit_w[g])
    );
    assign perm_w[g] = {cfg_w[g].lock, cfg_w[g].r, cfg_w[g].w, cfg_w[g].x};
  end

  pmp_resolve #(.N(NUM_ENTRIES)) u_resolve (
    .hit     (hit_w),
    .lrwx    (perm_w),
    .mml     (mml_w),
    .mmwp    (mmwp_w),
    .acc_type(acc_type),
    .acc_priv(acc_priv),
    .allow   (allow_w),
    .any_hit (any_hit_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_allow <= 1'b0;
      res_fault <= 1'b0;
    end else begin
      res_valid <= acc_valid;
      res_allow <= acc_valid & allow_w;
      res_fault <= acc_valid & ~allow_w;
    end
  end

  a_r13_result_next_cycle: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> res_valid);

  a_r5_lower_priv_unmatched: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_priv != PRIV_M && !any_hit_w) |=> res_fault);

  a_r5_whitelist_unmatched: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_priv == PRIV_M && !any_hit_w && mmwp_w) |=> res_fault);

  a_r7_lockdown_no_fetch: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_priv == PRIV_M && !any_hit_w && mml_w && acc_type == ACC_X)
      |=> res_fault);

endmodule

// File: tb/sim_pmp_guard.sv
module sim_pmp_guard;

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_kind = 2'd0;
  logic [3:0]  csr_idx = 4'd0;
  logic [31:0] csr_wdata = 32'd0;
  logic        acc_valid = 1'b0;
  logic [33:0] acc_addr = 34'd0;
  logic [1:0]  acc_type = 2'd0;
  logic [1:0]  acc_priv = 2'd0;
  logic        res_valid, res_allow, res_fault, flush_o;

  int nchk = 0;
  int nerr = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  pmp_guard u0 (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_kind(csr_kind), .csr_idx(csr_idx),
    .csr_wdata(csr_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_type(acc_type), .acc_priv(acc_priv), .res_valid(res_valid),
    .res_allow(res_allow), .res_fault(res_fault), .flush_o(flush_o)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  // monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b1, 1'b0, "R13 unexpected result");
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(res_allow, e, t);
        check(res_fault, ~e, {t, " fault"});
      end
    end
  end

  task automatic access(input logic [33:0] a, input logic [1:0] t, input logic [1:0] p,
                        input logic exp, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_type = t; acc_priv = p;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic csr_wr(input logic [1:0] k, input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_kind = k; csr_idx = i; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
    check(flush_o, (k != 2'd3), "R12 flush after write");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, 1'b1, "watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(res_valid, 1'b0, "R1 reset res_valid");
    check(flush_o, 1'b0, "R1 reset flush");
    rst = 1'b0;
    @(negedge clk);
    check(res_valid, 1'b0, "R1 idle res_valid");
    check(flush_o, 1'b0, "R1 idle flush");

    // empty table
    access(34'h1000, RD, PM, 1'b1, "R1 R5 M read empty");
    access(34'h1000, RD, PS, 1'b0, "R5 S read empty");
    access(34'h1000, EX, PU, 1'b0, "R5 U exec empty");
    access(34'h9000, 2'd3, PM, 1'b0, "R4 reserved kind");

    // NA4 entry0 read-only
    csr_wr(2'd1, 4'd0, 32'h400);
    csr_wr(2'd0, 4'd0, 32'h0000_0011);
    access(34'h1000, RD, PS, 1'b1, "R2 NA4 S read");
    access(34'h1000, WR, PS, 1'b0, "R4 NA4 S write");
    access(34'h1004, RD, PS, 1'b0, "R2 NA4 next word");
    access(34'h1000, WR, PM, 1'b1, "R4 M bypass unlocked");

    // NAPOT entry1 RW over 0x2000..0x20FF, TOR entry2 X above it
    csr_wr(2'd1, 4'd1, 32'h81F);
    csr_wr(2'd1, 4'd2, 32'hC00);
    csr_wr(2'd0, 4'd0, 32'h000C_1B11);
    access(34'h20FC, WR, PS, 1'b1, "R2 NAPOT top");
    access(34'h2100, WR, PS, 1'b0, "R2 NAPOT beyond");
    access(34'h2000, EX, PS, 1'b0, "R4 NAPOT no X");
    access(34'h2800, EX, PU, 1'b1, "R2 TOR inside");
    access(34'h3000, EX, PU, 1'b0, "R2 TOR upper bound");
    access(34'h2080, EX, PU, 1'b0, "R3 lower index wins");
    access(34'h2080, WR, PU, 1'b1, "R3 lower index RW");

    // locked entry3 read-only, then rewrite via bypass
    csr_wr(2'd1, 4'd3, 32'h1000);
    csr_wr(2'd0, 4'd0, 32'h910C_1B11);
    access(34'h4000, WR, PM, 1'b0, "R4 locked applies to M");
    access(34'h4000, RD, PM, 1'b1, "R4 locked M read");
    csr_wr(2'd0, 4'd0, 32'h930C_1B11);
    access(34'h4000, WR, PM, 1'b1, "R11 bypass rewrite");

    // TOR region entry5 set up before locking
    csr_wr(2'd1, 4'd4, 32'h1800);
    csr_wr(2'd1, 4'd5, 32'h1C00);

    // clear bypass, try to re-arm it, then try locked rewrites
    csr_wr(2'd2, 4'd0, 32'h0);
    csr_wr(2'd2, 4'd0, 32'h4);
    csr_wr(2'd0, 4'd0, 32'h910C_1B11);
    access(34'h4000, WR, PM, 1'b1, "R9 R10 locked cfg kept");
    csr_wr(2'd1, 4'd3, 32'h1400);
    access(34'h4000, EX, PM, 1'b0, "R10 locked addr kept");
    csr_wr(2'd0, 4'd1, 32'h0000_8900);
    csr_wr(2'd1, 4'd4, 32'h1A00);
    access(34'h6400, WR, PM, 1'b0, "R10 TOR lower bound kept");
    access(34'h6400, RD, PM, 1'b1, "R10 TOR locked read");
    csr_wr(2'd3, 4'd0, 32'h0);

    // whitelist
    csr_wr(2'd2, 4'd0, 32'h2);
    access(34'h9000, RD, PM, 1'b0, "R5 whitelist denies");
    csr_wr(2'd2, 4'd0, 32'h0);
    access(34'h9000, RD, PM, 1'b1, "R9 whitelist cleared");

    // shared entries, then lockdown
    csr_wr(2'd1, 4'd6, 32'h2000);
    csr_wr(2'd1, 4'd7, 32'h2040);
    csr_wr(2'd0, 4'd1, 32'h9212_8900);
    csr_wr(2'd2, 4'd0, 32'h1);
    access(34'h1000, RD, PM, 1'b0, "R6 user-only denies M");
    access(34'h1000, RD, PS, 1'b1, "R6 user-only S read");
    access(34'h4000, WR, PM, 1'b1, "R6 M-only write");
    access(34'h4000, RD, PS, 1'b0, "R6 M-only denies S");
    access(34'h8000, WR, PM, 1'b1, "R6 shared data M write");
    access(34'h8000, RD, PU, 1'b1, "R6 shared data U read");
    access(34'h8000, WR, PU, 1'b0, "R6 shared data U write");
    access(34'h8100, EX, PM, 1'b1, "R6 shared code M exec");
    access(34'h8100, EX, PU, 1'b1, "R6 shared code U exec");
    access(34'h8100, RD, PM, 1'b0, "R6 shared code M read");
    access(34'h9000, EX, PM, 1'b0, "R7 unmatched M exec");
    access(34'h9000, RD, PM, 1'b1, "R7 unmatched M read");
    csr_wr(2'd2, 4'd0, 32'h0);
    access(34'h1000, RD, PM, 1'b0, "R8 lockdown stays");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, 1'b1, "R13 all results seen");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule